// File: doc/BRIEF.md
# Time-Interleaved ADC Cyclic Compensation Equalizer

This block sits directly behind a four-way time-interleaved ADC and cleans up the mismatch between the converter branches. Each incoming sample belongs to a branch, and that branch follows from the sample's index. A per-branch DC estimate is first removed from the sample. The cleaned stream then passes through a five-tap FIR. The coefficient set of this FIR changes with the branch of the current sample, so the filter as a whole is periodically time-varying.

The coefficients adapt in the background by LMS. The error comes from a later part of the receiver, which backpropagates it to this block and labels it with the branch it refers to. Updates can be thinned by a decimation setting to ease timing. The step size is either a fixed small value, or a larger value that drops to the small tracking value after a programmable number of updates. While a freeze control is held, branch 0 is pinned to a pure delay, so that it cannot fight the adaptive blocks further down the chain.

Top module: `tiadc_cyclic_eq`

## Requirements
- R1: While reset is applied, out_valid and out_sample are 0. Coming out of reset, every branch holds a unit center tap (value 4096, 12 fractional bits, at tap 2) with the other taps at 0, all DC estimates are 0 and the sample history is 0.
- R2: out_valid equals in_valid one clock earlier, and out_sample takes the result of the sample accepted in that earlier cycle.
- R3: The branch of a sample is its accepted-sample count modulo 4. The count starts at 0 after reset and advances only when in_valid is high.
- R4: The DC removal keeps an 18-bit accumulator A per branch. The cleaned sample is c = sat12(x - (A >>> 4)), and on each accepted sample of that branch A becomes A + c.
- R5: For a sample on branch p, out_sample = sat12((sum over k=0..4 of w[p][k]*c[n-k]) >>> 12). Here c[n] is the newest cleaned sample and c[n-k] are the cleaned samples accepted before it, whatever their branch.
- R6: An applied update on branch b sets w[b][k] = sat16(w[b][k] + ((e * v[b][k]) >>> s)). Here v[b] is the five-entry input vector of the most recent sample filtered on branch b, and err_branch selects b.
- R7: The error strobes are counted. With decim = D, only the first strobe of each group of D+1 consecutive strobes applies an update, and the others are ignored.
- R8: With step_mode = 1, the first gear_len applied update events use s = 6, and all later events use s = 9. The event count saturates at 4095 and is cleared only by reset.
- R9: With step_mode = 0, every update uses s = 9.
- R10: While freeze_ref is high, branch 0 holds unit-delay taps from the next cycle on, and its updates are dropped. Such an event still counts toward R7 and R8.
- R11: When a sample and an update arrive in the same cycle, the sample is filtered with the taps from before the update. The update uses the stored vector from before this sample is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | ADC sample strobe |
| in_sample | input | 12 | Signed ADC sample |
| err_valid | input | 1 | Backpropagated error strobe |
| err_branch | input | 2 | Branch the error refers to |
| err_value | input | 12 | Signed backpropagated error |
| step_mode | input | 1 | 0 fixed step, 1 gear-shifted step |
| gear_len | input | 12 | Number of update events run at the large step |
| decim | input | 4 | Error strobes skipped after each applied one |
| freeze_ref | input | 1 | Pin branch 0 to a pure delay |
| out_valid | output | 1 | Compensated sample strobe |
| out_sample | output | 12 | Signed compensated sample |

## Verification
The error for branch b can arrive in the same cycle as a new sample on branch b. In that cycle the filter reads the tap set that the update is about to rewrite, and the update reads the stored vector that the new sample is about to replace. The bench steps the error branch along a pattern unrelated to the sample phase, so this collision occurs many times across every decimation, step-mode and freeze setting. A bench model that always applies the update after filtering, using the old vector, predicts every output sample, so any difference in ordering shows up in later outputs.

// File: rtl/tce_pkg.sv
package tce_pkg;
  typedef enum logic {
    STEP_FIXED = 1'b0,
    STEP_GEAR  = 1'b1
  } step_mode_e;
endpackage

// File: rtl/tce_dc_strip.sv
module tce_dc_strip #(
  parameter int NBR   = 4,
  parameter int XW    = 12,
  parameter int DC_SH = 4,
  parameter int BW    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [BW-1:0]        phase,
  input  logic signed [XW-1:0] x_in,
  output logic signed [XW-1:0] x_clean
);
  localparam int AW = XW + DC_SH + 2;
  localparam int DW = AW + 1;
  localparam logic signed [DW-1:0] CHI = DW'((1 << (XW-1)) - 1);
  localparam logic signed [DW-1:0] CLO = DW'(-(1 << (XW-1)));

  logic signed [AW-1:0] acc_q [NBR];
  logic signed [AW-1:0] acc_d [NBR];
  logic signed [AW-1:0] off;
  logic signed [DW-1:0] diff;

  always_comb begin
    off  = acc_q[phase] >>> DC_SH;
    diff = DW'(x_in) - DW'(off);
    if (diff > CHI)      x_clean = XW'(CHI);
    else if (diff < CLO) x_clean = XW'(CLO);
    else                 x_clean = XW'(diff);
    acc_d = acc_q;
    if (in_valid) acc_d[phase] = acc_q[phase] + AW'(x_clean);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBR; b++) acc_q[b] <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  for (genvar b = 0; b < NBR; b++) begin : g_acc_chk
    // R4
    acc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && phase == BW'(b)) |=> $stable(acc_q[b]));
  end
endmodule

// File: rtl/tce_coef_bank.sv
module tce_coef_bank
  import tce_pkg::*;
#(
  parameter int NBR     = 4,
  parameter int NTAP    = 5,
  parameter int XW      = 12,
  parameter int EW      = 12,
  parameter int CW      = 16,
  parameter int FRAC    = 12,
  parameter int MU_FAST = 6,
  parameter int MU_SLOW = 9,
  parameter int DECW    = 4,
  parameter int GCW     = 12,
  parameter int BW      = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [BW-1:0]              phase,
  input  logic [NTAP-1:0][XW-1:0]    x_vec,
  input  logic                       err_valid,
  input  logic [BW-1:0]              err_branch,
  input  logic signed [EW-1:0]       err_value,
  input  logic                       step_mode,
  input  logic [GCW-1:0]             gear_len,
  input  logic [DECW-1:0]            decim,
  input  logic                       freeze_ref,
  output logic [NTAP-1:0][CW-1:0]    taps_sel
);
  localparam int PW  = EW + XW;
  localparam int SW  = ((PW > CW) ? PW : CW) + 1;
  localparam int SHW = $clog2(PW + 1);
  localparam logic signed [SW-1:0] WHI = SW'((1 << (CW-1)) - 1);
  localparam logic signed [SW-1:0] WLO = SW'(-(1 << (CW-1)));

  function automatic logic [NTAP-1:0][CW-1:0] unit_taps();
    logic [NTAP-1:0][CW-1:0] t;
    t = '0;
    t[NTAP/2] = CW'(1) << FRAC;
    return t;
  endfunction
  localparam logic [NTAP-1:0][CW-1:0] UNIT_TAPS = unit_taps();

  logic [NTAP-1:0][CW-1:0] w_q [NBR];
  logic [NTAP-1:0][CW-1:0] w_d [NBR];
  logic [NTAP-1:0][XW-1:0] v_q [NBR];
  logic [NTAP-1:0][XW-1:0] v_d [NBR];
  logic [DECW-1:0]         dec_q, dec_d;
  logic [GCW-1:0]          upd_q, upd_d;
  logic                    fire;
  logic [SHW-1:0]          shamt;
  logic signed [PW-1:0]    prod;
  logic signed [PW-1:0]    delta;
  logic signed [SW-1:0]    sum;

  always_comb begin
    fire  = err_valid && (dec_q == '0);
    dec_d = dec_q;
    if (err_valid) dec_d = (dec_q >= decim) ? '0 : dec_q + DECW'(1);
    upd_d = upd_q;
    if (fire && upd_q != {GCW{1'b1}}) upd_d = upd_q + GCW'(1);
    shamt = (step_mode_e'(step_mode) == STEP_GEAR && upd_q < gear_len)
            ? SHW'(MU_FAST) : SHW'(MU_SLOW);
    prod  = '0;
    delta = '0;
    sum   = '0;
    w_d   = w_q;
    if (fire && !(freeze_ref && err_branch == '0)) begin
      for (int k = 0; k < NTAP; k++) begin
        prod  = $signed(err_value) * $signed(v_q[err_branch][k]);
        delta = prod >>> shamt;
        sum   = SW'(delta) + SW'($signed(w_q[err_branch][k]));
        if (sum > WHI)      w_d[err_branch][k] = CW'(WHI);
        else if (sum < WLO) w_d[err_branch][k] = CW'(WLO);
        else                w_d[err_branch][k] = CW'(sum);
      end
    end
    if (freeze_ref) w_d[0] = UNIT_TAPS;
    v_d = v_q;
    if (in_valid) v_d[phase] = x_vec;
  end

  assign taps_sel = w_q[phase];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBR; b++) begin
        w_q[b] <= UNIT_TAPS;
        v_q[b] <= '0;
      end
      dec_q <= '0;
      upd_q <= '0;
    end else begin
      w_q   <= w_d;
      v_q   <= v_d;
      dec_q <= dec_d;
      upd_q <= upd_d;
    end
  end

  logic ref_is_unit;
  assign ref_is_unit = (w_q[0] == UNIT_TAPS);

  // R10
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_ref |=> ref_is_unit);

  // R8
  gear_count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> upd_q >= $past(upd_q));

  // R7
  decim_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && dec_q != '0) |=> $stable(upd_q));

  for (genvar b = 0; b < NBR; b++) begin : g_tap_chk
    // R6
    taps_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(fire && err_branch == BW'(b)) && !(b == 0 && freeze_ref)) |=> $stable(w_q[b]));
  end
endmodule

// File: rtl/tce_tap_line.sv
module tce_tap_line #(
  parameter int NTAP = 5,
  parameter int XW   = 12,
  parameter int CW   = 16,
  parameter int FRAC = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [XW-1:0]     x_clean,
  input  logic [NTAP-1:0][CW-1:0]  taps,
  output logic [NTAP-1:0][XW-1:0]  x_vec,
  output logic                     out_valid,
  output logic signed [XW-1:0]     out_sample
);
  localparam int MW = CW + XW + $clog2(NTAP) + 1;
  localparam logic signed [MW-1:0] YHI = MW'((1 << (XW-1)) - 1);
  localparam logic signed [MW-1:0] YLO = MW'(-(1 << (XW-1)));

  logic [NTAP-1:1][XW-1:0] hist_q, hist_d;
  logic signed [CW+XW-1:0] pr;
  logic signed [MW-1:0]    acc;
  logic signed [MW-1:0]    scaled;
  logic signed [XW-1:0]    y_d;

  assign x_vec[0] = x_clean;
  for (genvar k = 1; k < NTAP; k++) begin : g_vec
    assign x_vec[k] = hist_q[k];
  end

  always_comb begin
    hist_d = hist_q;
    if (in_valid) begin
      hist_d[1] = x_clean;
      for (int k = 2; k < NTAP; k++) hist_d[k] = hist_q[k-1];
    end
    acc = '0;
    pr  = '0;
    for (int k = 0; k < NTAP; k++) begin
      pr  = $signed(taps[k]) * $signed(x_vec[k]);
      acc = acc + MW'(pr);
    end
    scaled = acc >>> FRAC;
    if (scaled > YHI)      y_d = XW'(YHI);
    else if (scaled < YLO) y_d = XW'(YLO);
    else                   y_d = XW'(scaled);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q     <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      hist_q    <= hist_d;
      out_valid <= in_valid;
      if (in_valid) out_sample <= y_d;
    end
  end

  // R2
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sample));
endmodule

// File: rtl/tiadc_cyclic_eq.sv
module tiadc_cyclic_eq #(
  parameter int NBR     = 4,
  parameter int NTAP    = 5,
  parameter int XW      = 12,
  parameter int EW      = 12,
  parameter int CW      = 16,
  parameter int FRAC    = 12,
  parameter int DC_SH   = 4,
  parameter int MU_FAST = 6,
  parameter int MU_SLOW = 9,
  parameter int DECW    = 4,
  parameter int GCW     = 12,
  localparam int BW     = $clog2(NBR)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [XW-1:0] in_sample,
  input  logic                 err_valid,
  input  logic [BW-1:0]        err_branch,
  input  logic signed [EW-1:0] err_value,
  input  logic                 step_mode,
  input  logic [GCW-1:0]       gear_len,
  input  logic [DECW-1:0]      decim,
  input  logic                 freeze_ref,
  output logic                 out_valid,
  output logic signed [XW-1:0] out_sample
);
  logic rs_meta, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_n_i <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_n_i <= rs_meta;
    end
  end

  logic [BW-1:0] phase_q, phase_d;
  always_comb begin
    phase_d = phase_q;
    if (in_valid) phase_d = (phase_q == BW'(NBR-1)) ? '0 : phase_q + BW'(1);
  end
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) phase_q <= '0;
    else          phase_q <= phase_d;
  end

  logic signed [XW-1:0]    x_clean;
  logic [NTAP-1:0][XW-1:0] x_vec;
  logic [NTAP-1:0][CW-1:0] taps_sel;

  tce_dc_strip #(.NBR(NBR), .XW(XW), .DC_SH(DC_SH), .BW(BW)) u_dc (
    .clk(clk), .rst_n(rst_n_i), .in_valid(in_valid), .phase(phase_q),
    .x_in(in_sample), .x_clean(x_clean));

  tce_tap_line #(.NTAP(NTAP), .XW(XW), .CW(CW), .FRAC(FRAC)) u_line (
    .clk(clk), .rst_n(rst_n_i), .in_valid(in_valid), .x_clean(x_clean),
    .taps(taps_sel), .x_vec(x_vec), .out_valid(out_valid), .out_sample(out_sample));

  tce_coef_bank #(.NBR(NBR), .NTAP(NTAP), .XW(XW), .EW(EW), .CW(CW), .FRAC(FRAC),
    .MU_FAST(MU_FAST), .MU_SLOW(MU_SLOW), .DECW(DECW), .GCW(GCW), .BW(BW)) u_bank (
    .clk(clk), .rst_n(rst_n_i), .in_valid(in_valid), .phase(phase_q), .x_vec(x_vec),
    .err_valid(err_valid), .err_branch(err_branch), .err_value(err_value),
    .step_mode(step_mode), .gear_len(gear_len), .decim(decim),
    .freeze_ref(freeze_ref), .taps_sel(taps_sel));

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !in_valid |=> !out_valid);
  // R3
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (in_valid && phase_q == BW'(NBR-1)) |=> phase_q == '0);
  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !in_valid |=> $stable(phase_q));
endmodule

// File: tb/tiadc_cyclic_eq_test.sv
`timescale 1ns/1ps
module tiadc_cyclic_eq_test;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, err_valid, step_mode, freeze_ref;
  logic signed [11:0] in_sample, err_value;
  logic [1:0]  err_branch;
  logic [11:0] gear_len;
  logic [3:0]  decim;
  logic out_valid;
  logic signed [11:0] out_sample;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tiadc_cyclic_eq uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .err_valid(err_valid), .err_branch(err_branch), .err_value(err_value),
    .step_mode(step_mode), .gear_len(gear_len), .decim(decim),
    .freeze_ref(freeze_ref), .out_valid(out_valid), .out_sample(out_sample));

  // Bench-side arithmetic model of the requirements
  int dacc[4];
  int hist[4];
  int w[4][5];
  int vst[4][5];
  int mph, dcnt, ucnt;

  function automatic int sat(int v, int bits);
    int hi = (1 << (bits-1)) - 1;
    int lo = -(1 << (bits-1));
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  task automatic check(bit ok, string req, int got, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 4; b++) begin
      dacc[b] = 0;
      hist[b] = 0;
      for (int k = 0; k < 5; k++) begin
        w[b][k] = (k == 2) ? 4096 : 0;
        vst[b][k] = 0;
      end
    end
    mph = 0; dcnt = 0; ucnt = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 0; err_valid = 0; in_sample = '0; err_value = '0; err_branch = '0;
    step_mode = 0; gear_len = '0; decim = '0; freeze_ref = 0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(out_sample == '0, "R1 out_sample", int'(out_sample), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  // One cycle: drive at negedge, predict, clock, compare at the next negedge.
  // Covers R3 (branch order), R4 (DC), R5 (FIR), R6 (LMS), R7 (decimation),
  // R8 (gear), R9 (fixed step), R10 (freeze) and R11 (same-cycle collision).
  task automatic step(bit iv, int x, bit ev, int eb, int e,
                      bit md, int dec, bit frz, int glen);
    int xv[5];
    int c, acc, y, sh;
    bit fire;
    in_valid = iv; in_sample = 12'(x); err_valid = ev; err_branch = 2'(eb);
    err_value = 12'(e); step_mode = md; decim = 4'(dec); freeze_ref = frz;
    gear_len = 12'(glen);
    y = 0; c = 0;
    for (int k = 0; k < 5; k++) xv[k] = 0;
    if (iv) begin
      c = sat(x - (dacc[mph] >>> 4), 12);
      xv[0] = c;
      for (int k = 1; k < 5; k++) xv[k] = hist[k-1];
      acc = 0;
      for (int k = 0; k < 5; k++) acc += w[mph][k] * xv[k];
      y = sat(acc >>> 12, 12);
    end
    fire = ev && (dcnt == 0);
    if (fire) begin
      sh = (md && ucnt < glen) ? 6 : 9;
      if (!(frz && eb == 0))
        for (int k = 0; k < 5; k++) w[eb][k] = sat(w[eb][k] + ((e * vst[eb][k]) >>> sh), 16);
      if (ucnt < 4095) ucnt++;
    end
    if (ev) dcnt = (dcnt >= dec) ? 0 : dcnt + 1;
    if (frz) for (int k = 0; k < 5; k++) w[0][k] = (k == 2) ? 4096 : 0;
    if (iv) begin
      dacc[mph] += c;
      for (int k = 0; k < 5; k++) vst[mph][k] = xv[k];
      for (int k = 3; k >= 1; k--) hist[k] = hist[k-1];
      hist[0] = c;
      mph = (mph + 1) % 4;
    end
    @(posedge clk);
    @(negedge clk);
    check(out_valid == iv, "R2 out_valid", int'(out_valid), int'(iv));
    if (iv)
      check(int'(out_sample) == y, "R3/R4/R5/R6/R7/R8/R9/R10/R11 out_sample",
            int'(out_sample), y);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++;
      $display("FAIL R2 watchdog: got no completion expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    @(negedge clk);
    for (int cfg = 0; cfg < 16; cfg++) begin
      bit md, fz;
      int dec;
      md  = cfg[0];
      fz  = cfg[1];
      dec = cfg[3:2];
      do_reset();
      for (int i = 0; i < 90; i++) begin
        bit iv, ev, frz;
        int x, eb, e;
        iv = (i % 7) != 6;
        x = ((i * 37 + cfg * 11) % 301) - 150 + 400 * mph - 600;
        if (i % 13 == 5) x = 2047;
        if (i % 13 == 9) x = -2048;
        ev = (i % 5) != 4;
        eb = (i * 3 + cfg) % 4;
        e = ((i * 53 + cfg * 7) % 801) - 400;
        if (i % 17 == 3) e = 2047;
        if (i % 19 == 7) e = -2048;
        frz = fz ^ (i >= 45 && i < 60);
        step(iv, x, ev, eb, e, md, dec, frz, 6);
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule